// File: doc/BRIEF.md
# Debug Mailbox Handshake Register

This block is a mailbox between an external debugger and a debug handler that runs on the core. The debugger side has strobe ports that push a word into a receive data register, pull the word from a transmit data register, and clear a sticky error flag. The handler side is a small register port with a select, a read strobe and a write strobe. It reaches the receive data, the transmit data and a 32-bit control/status word.

The status word carries four flags. Receive-ready is raised by a debugger write and dropped by a handler read. Receive-overflow latches any debugger write that arrives while the previous word is still unread. Transmit-ready is raised by a handler write and dropped by a debugger read. The fast-download flag is owned by software and tells the debugger that it may stream words without polling. The debugger sees receive-ready, transmit-ready and the fast-download flag on dedicated outputs, which stand in for polling through the scan chain.

Both ports run in one clock domain with an active-low synchronous reset. A parameter decides what happens on overflow: the incoming word is either dropped or allowed to overwrite the unread one.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the status word reads 0x0000_0000, and `dbg_rx_ready`, `dbg_tx_ready`, `dbg_hs_mode` and `dbg_tx_rdata` are all 0.
- R2: A debugger receive write (`dbg_rx_wr`) stores `dbg_rx_wdata` and sets receive-ready. Receive-ready is status bit 31 and is also seen on `dbg_rx_ready` from the next cycle on.
- R3: A handler read of select 0 (receive data) with `sw_rd` high returns the stored word on `sw_rdata` in the same cycle. It clears receive-ready from the next cycle on.
- R4: A debugger receive write that arrives while receive-ready is set, with no handler receive read in the same cycle, sets overflow (status bit 30). With `RX_OVERWRITE`=0 the stored word is kept; with `RX_OVERWRITE`=1 it is replaced by the new word.
- R5: Overflow stays set through handler reads and handler writes to the status word. Only `dbg_ovf_clr` or reset clears it.
- R6: Status bit 29 (fast-download) is written by a handler write to select 2 and read back from the same select. It is also driven on `dbg_hs_mode`.
- R7: Status bits 27:0 always read as zero. Handler writes to bits 31, 30 and 28 have no effect. Select 3 reads as zero.
- R8: A handler write to select 1 (transmit data) stores the word and sets transmit-ready (status bit 28, also on `dbg_tx_ready`). The stored word is shown on `dbg_tx_rdata`, and `dbg_tx_rd` clears transmit-ready.
- R9: When a debugger receive write and a handler receive read occur in the same cycle, the read returns the old word. Afterwards receive-ready is set, the new word is stored, and overflow is not raised.
- R10: When a handler transmit write and a debugger transmit read occur in the same cycle, the debugger sees the old word. Afterwards transmit-ready is set and the new word is stored.
- R11: When an overflowing receive write and `dbg_ovf_clr` occur in the same cycle, overflow ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_rx_wr | input | 1 | Debugger write strobe for receive data |
| dbg_rx_wdata | input | DATA_W | Debugger receive word |
| dbg_ovf_clr | input | 1 | Debugger clear of the overflow flag |
| dbg_tx_rd | input | 1 | Debugger read strobe for transmit data |
| dbg_tx_rdata | output | DATA_W | Transmit word seen by the debugger |
| dbg_rx_ready | output | 1 | Receive-ready flag, for debugger polling |
| dbg_tx_ready | output | 1 | Transmit-ready flag, for debugger polling |
| dbg_hs_mode | output | 1 | Fast-download flag |
| sw_sel | input | 2 | Handler select: 0 receive, 1 transmit, 2 status, 3 none |
| sw_rd | input | 1 | Handler read strobe |
| sw_wr | input | 1 | Handler write strobe |
| sw_wdata | input | DATA_W | Handler write word |
| sw_rdata | output | DATA_W | Handler read word (combinational on select) |

## Verification
The bench builds two copies of the block with `DATA_W`=32. One uses the default `RX_OVERWRITE`=0 and the other uses `RX_OVERWRITE`=1. Both copies get the same stimulus. The two copies diverge only when a receive word is read after an overflow, so a single sequence shows both the drop and the replace outcome side by side. Every other check runs on the default copy.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

    // Handler-side select encoding
    typedef enum logic [1:0] {
        SEL_RXDAT = 2'd0,
        SEL_TXDAT = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    // Status word flag positions (decoded by the handler software)
    localparam int STAT_RXRDY_BIT = 31;
    localparam int STAT_RXOVF_BIT = 30;
    localparam int STAT_HSDL_BIT  = 29;
    localparam int STAT_TXRDY_BIT = 28;
    localparam int STAT_MIN_W     = 32;

endpackage

// File: rtl/dbgmb_rx_chan.sv
module dbgmb_rx_chan #(
    parameter int DATA_W       = 32,
    parameter bit RX_OVERWRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              ovf_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              ovf;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   collide;
    logic   take_word;

    always_comb begin
        st_d      = st_q;
        collide   = wr_i && st_q.ready && !rd_i;
        take_word = wr_i && (!collide || RX_OVERWRITE);

        if (take_word) begin
            st_d.data = wdata_i;
        end

        if (wr_i) begin
            st_d.ready = 1'b1;
        end else if (rd_i) begin
            st_d.ready = 1'b0;
        end

        if (collide) begin
            st_d.ovf = 1'b1;
        end else if (ovf_clr_i) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign ready_o = st_q.ready;
    assign ovf_o   = st_q.ovf;

    // R2
    rx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ready_o && data_o == $past(wdata_i)) || (!RX_OVERWRITE && ovf_o));

    // R3
    rx_ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i) |=> !ready_o);

    // R4
    rx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ready_o && !rd_i) |=> ovf_o);

    // R4
    rx_drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!RX_OVERWRITE && wr_i && ready_o && !rd_i) |=> $stable(data_o));

    // R5
    rx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    // R9
    rx_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && rd_i && !ovf_o) |=> (ready_o && !ovf_o));

endmodule

// File: rtl/dbgmb_tx_chan.sv
module dbgmb_tx_chan #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.data  = wdata_i;
            st_d.ready = 1'b1;
        end else if (rd_i) begin
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign ready_o = st_q.ready;

    // R8
    tx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (ready_o && data_o == $past(wdata_i)));

    // R8
    tx_ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !wr_i) |=> !ready_o);

endmodule

// File: rtl/dbgmb_sw_port.sv
module dbgmb_sw_port
    import dbgmb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              hs_wbit_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              rx_ready_i,
    input  logic              rx_ovf_i,
    input  logic              tx_ready_i,
    output logic              rx_rd_o,
    output logic              tx_wr_o,
    output logic              hs_mode_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic hs;
    } sw_st_t;

    sw_st_t            st_d, st_q;
    sel_e              sel;
    logic [DATA_W-1:0] stat_word;

    assign sel = sel_e'(sel_i);

    always_comb begin
        st_d = st_q;
        if (wr_i && sel == SEL_STAT) begin
            st_d.hs = hs_wbit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_word                 = '0;
        stat_word[STAT_RXRDY_BIT] = rx_ready_i;
        stat_word[STAT_RXOVF_BIT] = rx_ovf_i;
        stat_word[STAT_HSDL_BIT]  = st_q.hs;
        stat_word[STAT_TXRDY_BIT] = tx_ready_i;
    end

    always_comb begin
        unique case (sel)
            SEL_RXDAT: rdata_o = rx_data_i;
            SEL_TXDAT: rdata_o = tx_data_i;
            SEL_STAT:  rdata_o = stat_word;
            default:   rdata_o = '0;
        endcase
    end

    assign rx_rd_o   = rd_i && sel == SEL_RXDAT;
    assign tx_wr_o   = wr_i && sel == SEL_TXDAT;
    assign hs_mode_o = st_q.hs;

    // R6
    hs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_STAT) |=> (hs_mode_o == $past(hs_wbit_i)));

    // R6
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel == SEL_STAT) |=> $stable(hs_mode_o));

    // R7
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_STAT) |-> (rdata_o[STAT_TXRDY_BIT-1:0] == '0));

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter bit RX_OVERWRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_rx_wr,
    input  logic [DATA_W-1:0] dbg_rx_wdata,
    input  logic              dbg_ovf_clr,
    input  logic              dbg_tx_rd,
    output logic [DATA_W-1:0] dbg_tx_rdata,
    output logic              dbg_rx_ready,
    output logic              dbg_tx_ready,
    output logic              dbg_hs_mode,
    input  logic [1:0]        sw_sel,
    input  logic              sw_rd,
    input  logic              sw_wr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata
);

    localparam int HS_POS = STAT_HSDL_BIT;

    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] tx_data;
    logic              rx_ready;
    logic              rx_ovf;
    logic              tx_ready;
    logic              rx_rd;
    logic              tx_wr;
    logic              hs_mode;

    generate
        if (DATA_W < STAT_MIN_W) begin : g_width_bad
            initial $error("DATA_W must be at least 32");
        end
    endgenerate

    dbgmb_rx_chan #(
        .DATA_W       (DATA_W),
        .RX_OVERWRITE (RX_OVERWRITE)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (dbg_rx_wr),
        .wdata_i   (dbg_rx_wdata),
        .rd_i      (rx_rd),
        .ovf_clr_i (dbg_ovf_clr),
        .data_o    (rx_data),
        .ready_o   (rx_ready),
        .ovf_o     (rx_ovf)
    );

    dbgmb_tx_chan #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (tx_wr),
        .wdata_i (sw_wdata),
        .rd_i    (dbg_tx_rd),
        .data_o  (tx_data),
        .ready_o (tx_ready)
    );

    dbgmb_sw_port #(
        .DATA_W (DATA_W)
    ) u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sw_sel),
        .rd_i       (sw_rd),
        .wr_i       (sw_wr),
        .hs_wbit_i  (sw_wdata[HS_POS]),
        .rx_data_i  (rx_data),
        .tx_data_i  (tx_data),
        .rx_ready_i (rx_ready),
        .rx_ovf_i   (rx_ovf),
        .tx_ready_i (tx_ready),
        .rx_rd_o    (rx_rd),
        .tx_wr_o    (tx_wr),
        .hs_mode_o  (hs_mode),
        .rdata_o    (sw_rdata)
    );

    assign dbg_tx_rdata = tx_data;
    assign dbg_rx_ready = rx_ready;
    assign dbg_tx_ready = tx_ready;
    assign dbg_hs_mode  = hs_mode;

    // R7
    stat_ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_sel == 2'd2 && !dbg_rx_wr && !dbg_ovf_clr && !dbg_tx_rd)
        |=> ($stable(dbg_rx_ready) && $stable(dbg_tx_ready)));

    // R11
    ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rx_wr && dbg_rx_ready && !(sw_rd && sw_sel == 2'd0) && dbg_ovf_clr)
        |=> sw_sel != 2'd2 || sw_rdata[STAT_RXOVF_BIT]);

endmodule

// File: tb/dbg_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_mailbox_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbg_rx_wr = 1'b0;
    logic [DW-1:0] dbg_rx_wdata = '0;
    logic          dbg_ovf_clr = 1'b0;
    logic          dbg_tx_rd = 1'b0;
    logic [1:0]    sw_sel = 2'd2;
    logic          sw_rd = 1'b0;
    logic          sw_wr = 1'b0;
    logic [DW-1:0] sw_wdata = '0;

    logic [DW-1:0] dbg_tx_rdata, sw_rdata;
    logic          dbg_rx_ready, dbg_tx_ready, dbg_hs_mode;
    logic [DW-1:0] ow_tx_rdata, ow_rdata;
    logic          ow_rx_ready, ow_tx_ready, ow_hs_mode;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dbg_mailbox #(.DATA_W(DW), .RX_OVERWRITE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dbg_rx_wr(dbg_rx_wr), .dbg_rx_wdata(dbg_rx_wdata),
        .dbg_ovf_clr(dbg_ovf_clr), .dbg_tx_rd(dbg_tx_rd),
        .dbg_tx_rdata(dbg_tx_rdata), .dbg_rx_ready(dbg_rx_ready),
        .dbg_tx_ready(dbg_tx_ready), .dbg_hs_mode(dbg_hs_mode),
        .sw_sel(sw_sel), .sw_rd(sw_rd), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    dbg_mailbox #(.DATA_W(DW), .RX_OVERWRITE(1'b1)) u_dut_ow (
        .clk(clk), .rst_n(rst_n),
        .dbg_rx_wr(dbg_rx_wr), .dbg_rx_wdata(dbg_rx_wdata),
        .dbg_ovf_clr(dbg_ovf_clr), .dbg_tx_rd(dbg_tx_rd),
        .dbg_tx_rdata(ow_tx_rdata), .dbg_rx_ready(ow_rx_ready),
        .dbg_tx_ready(ow_tx_ready), .dbg_hs_mode(ow_hs_mode),
        .sw_sel(sw_sel), .sw_rd(sw_rd), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .sw_rdata(ow_rdata)
    );

    typedef struct packed {
        logic          dwr;
        logic [31:0]   dwd;
        logic          clr;
        logic          dtrd;
        logic [1:0]    sel;
        logic          srd;
        logic          swr;
        logic [31:0]   swd;
        logic [31:0]   erd;
        logic [2:0]    efl;  // {rx_ready, hs_mode, tx_ready} before the edge
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,         3'b000}, // R1
        '{1'b1, 32'h1111_0001, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,         3'b000}, // R2
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h8000_0000, 3'b100}, // R2
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h0,         32'h1111_0001, 3'b100}, // R3
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,         3'b000}, // R3
        '{1'b1, 32'h2222_0002, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,         3'b000}, // R4
        '{1'b1, 32'h3333_0003, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h8000_0000, 3'b100}, // R4
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'hC000_0000, 3'b100}, // R4
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h0,         32'h2222_0002, 3'b100}, // R4
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 32'hD000_FFFF, 32'h4000_0000, 3'b000}, // R7
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h4000_0000, 3'b000}, // R5
        '{1'b0, 32'h0,         1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h4000_0000, 3'b000}, // R5
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,         3'b000}, // R5
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 32'h2000_0000, 32'h0,         3'b000}, // R6
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h2000_0000, 3'b010}, // R6
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 32'h5555_AAAA, 32'h0,         3'b010}, // R8
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h3000_0000, 3'b011}, // R8
        '{1'b0, 32'h0,         1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0,         32'h3000_0000, 3'b011}, // R8
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h2000_0000, 3'b010}, // R8
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 32'h0,         32'h2000_0000, 3'b010}, // R6
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0,         32'h0,         3'b000}, // R6
        '{1'b0, 32'h0,         1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 32'h0,         32'h0,         3'b000}  // R7
    };

    function automatic string row_tag(input int i);
        case (i)
            0:                   return "R1";
            1, 2:                return "R2";
            3, 4:                return "R3";
            5, 6, 7, 8:          return "R4";
            9, 21:               return "R7";
            10, 11, 12:          return "R5";
            15, 16, 17, 18:      return "R8";
            default:             return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic dwr, input logic [31:0] dwd, input logic clr,
                         input logic dtrd, input logic [1:0] sel, input logic srd,
                         input logic swr, input logic [31:0] swd);
        @(negedge clk);
        dbg_rx_wr    = dwr;
        dbg_rx_wdata = dwd;
        dbg_ovf_clr  = clr;
        dbg_tx_rd    = dtrd;
        sw_sel       = sel;
        sw_rd        = srd;
        sw_wr        = swr;
        sw_wdata     = swd;
        #1;
    endtask

    task automatic look(input logic [1:0] sel);
        drive(1'b0, '0, 1'b0, 1'b0, sel, 1'b0, 1'b0, '0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state before release
        check(sw_rdata == 32'h0 && !dbg_rx_ready && !dbg_tx_ready && !dbg_hs_mode,
              "R1", sw_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].dwr, VEC[i].dwd, VEC[i].clr, VEC[i].dtrd,
                  VEC[i].sel, VEC[i].srd, VEC[i].swr, VEC[i].swd);
            check(sw_rdata == VEC[i].erd, row_tag(i), sw_rdata, VEC[i].erd);
            check({dbg_rx_ready, dbg_hs_mode, dbg_tx_ready} == VEC[i].efl, row_tag(i),
                  {29'h0, dbg_rx_ready, dbg_hs_mode, dbg_tx_ready}, {29'h0, VEC[i].efl});
        end

        // R9: debugger write and handler read in the same cycle
        drive(1'b1, 32'h7777_0007, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, '0);
        drive(1'b1, 32'h8888_0008, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, '0);
        check(sw_rdata == 32'h7777_0007, "R9", sw_rdata, 32'h7777_0007);
        look(2'd2);
        check(sw_rdata == 32'h8000_0000, "R9", sw_rdata, 32'h8000_0000);
        drive(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, '0);
        check(sw_rdata == 32'h8888_0008, "R9", sw_rdata, 32'h8888_0008);

        // R10: handler transmit write and debugger transmit read together
        drive(1'b0, '0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 32'h9999_0009);
        drive(1'b0, '0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 32'hAAAA_000A);
        check(dbg_tx_rdata == 32'h9999_0009, "R10", dbg_tx_rdata, 32'h9999_0009);
        look(2'd2);
        check(dbg_tx_ready == 1'b1, "R10", {31'h0, dbg_tx_ready}, 32'h1);
        check(dbg_tx_rdata == 32'hAAAA_000A, "R10", dbg_tx_rdata, 32'hAAAA_000A);
        drive(1'b0, '0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, '0);
        look(2'd2);
        check(dbg_tx_ready == 1'b0, "R8", {31'h0, dbg_tx_ready}, 32'h0);

        // R4: drop versus overwrite on the two copies
        drive(1'b1, 32'h1234_0001, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, '0);
        drive(1'b1, 32'h1234_0002, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, '0);
        drive(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, '0);
        check(sw_rdata == 32'h1234_0001, "R4", sw_rdata, 32'h1234_0001);
        check(ow_rdata == 32'h1234_0002, "R4", ow_rdata, 32'h1234_0002);
        drive(1'b0, '0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, '0);
        check(ow_rdata == 32'h4000_0000, "R4", ow_rdata, 32'h4000_0000);
        look(2'd2);
        check(sw_rdata == 32'h0, "R5", sw_rdata, 32'h0);

        // R11: overflow set beats clear in the same cycle
        drive(1'b1, 32'h4444_0004, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, '0);
        drive(1'b1, 32'h4444_0005, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, '0);
        look(2'd2);
        check(sw_rdata == 32'hC000_0000, "R11", sw_rdata, 32'hC000_0000);
        drive(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, '0);
        check(sw_rdata == 32'h4444_0004, "R11", sw_rdata, 32'h4444_0004);

        // R1: reset in the middle of activity
        drive(1'b0, '0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 32'h2000_1234);
        drive(1'b0, '0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 32'h2000_0000);
        rst_n = 1'b0;
        look(2'd2);
        look(2'd2);
        check(sw_rdata == 32'h0 && !dbg_rx_ready && !dbg_tx_ready && !dbg_hs_mode
              && dbg_tx_rdata == 32'h0, "R1", sw_rdata, 32'h0);
        rst_n = 1'b1;
        look(2'd2);
        check(sw_rdata == 32'h0, "R1", sw_rdata, 32'h0);

        finish_run();
    end

endmodule